// File: doc/BRIEF.md
# Status Register Write Protection

This block keeps the eight-bit status register of a serial memory and decides, byte by byte, whether a write may land. An SPI front end that has already shifted in and decoded each command hands it over as a one-cycle event: set the enable latch, clear the enable latch, read status, write status (with its data byte), or write one memory byte (with its 19-bit address). The front end also pulses a transaction-start strobe when chip select falls. The block samples the write-protect pin at that instant and holds the sample until the next transaction starts.

Three things gate every write. The first is a volatile enable latch. The second is a sticky lock bit in the status register, which hands status-register changes over to the write-protect pin. The third is a two-bit block-protect field that fences off an upper part of the array. The permit for a memory byte is a combinational answer in the same cycle as the byte event, so the front end can drop a protected byte and still advance its address. Register contents stand in for non-volatile retention: only the power-on reset clears them.

Top module: `status_guard`

## Requirements
- R1: After power-on reset the status byte reads 00h, and neither the memory-write permit nor the status-update strobe is asserted.
- R2: Command code 1 (set enable) makes status bit 1 read 1 from the next cycle. Command code 2 (clear enable) makes it read 0.
- R3: While status bit 1 is 0, a memory-write event (code 5) gets no permit and a status-write event (code 4) leaves the status unchanged with no strobe.
- R4: A status write (code 4) takes effect when bit 1 is 1 and either bit 7 is 0 or the latched write-protect sample is high. The strobe is high in that cycle, and from the next cycle bits 7..2 and 0 equal the data byte.
- R5: When bit 7 is 1 and the latched write-protect sample is low, a status write is refused: no strobe, status unchanged.
- R6: Bits 3:2 select the guarded range by the top two address bits: 00 guards nothing, 01 guards addresses whose top two bits are 11, 10 guards addresses whose top bit is 1, and 11 guards every address. A memory write gets its permit only when bit 1 is 1 and its address is outside the guarded range.
- R7: Status writes and memory writes never change bit 1. Data bit 1 of a status write is ignored.
- R8: The write-protect pin is sampled only on the transaction-start strobe. A change of the pin later in the same transaction does not affect whether a status write is allowed.
- R9: The permit is evaluated separately for every byte of a streaming write. Consecutive addresses that cross into the guarded range lose the permit at the first guarded address.
- R10: Bits 6, 5, 4 and 0 are stored and read back as written, and they have no effect on any permit.
- R11: Status read (code 3), no-operation (code 0) and undefined codes (6, 7) change no state and raise neither output strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| txn_start | input | 1 | One-cycle pulse when chip select falls |
| wp_pin | input | 1 | Write-protect pin level, high means unprotected |
| cmd_valid | input | 1 | A decoded command event is present this cycle |
| cmd_kind | input | 3 | Command code (0 none, 1 set enable, 2 clear enable, 3 status read, 4 status write, 5 memory write) |
| cmd_data | input | 8 | Data byte of a status write |
| mem_addr | input | 19 | Byte address of a memory write |
| status_out | output | 8 | Current status byte |
| mem_wr_ok | output | 1 | Memory byte of this event may be written |
| stat_upd | output | 1 | Status write of this event is being carried out |

## Verification
The hardest case to reach is a status write that arrives while the lock bit is set and the write-protect pin has changed since the transaction began. The bench first unlocks and sets the lock bit with the pin high. It then opens one transaction with the pin low and raises the pin before the status write, and another transaction with the pin high that it lowers before the write. Whether each write is refused or carried out shows which pin sample the block used. Streaming writes that step across each block-protect boundary check that the permit follows every address.

// File: rtl/srwp_pkg.sv
package srwp_pkg;

    localparam int STAT_W   = 8;
    localparam int ADDR_W_D = 19;

    typedef enum logic [2:0] {
        CMD_NONE  = 3'd0,
        CMD_WEN   = 3'd1,
        CMD_WDIS  = 3'd2,
        CMD_RSTAT = 3'd3,
        CMD_WSTAT = 3'd4,
        CMD_MWR   = 3'd5
    } cmd_e;

    typedef struct packed {
        logic       lock;      // bit 7: hands status writes to the WP pin
        logic [2:0] spare_hi;  // bits 6..4: free bits
        logic [1:0] bp;        // bits 3..2: block guard select
        logic       wel;       // bit 1: volatile enable latch
        logic       spare_lo;  // bit 0: free bit
    } stat_t;

    // Is an address with these top two bits inside the guarded range?
    function automatic logic in_guarded(input logic [1:0] bp, input logic [1:0] top2);
        logic g;
        case (bp)
            2'b00:   g = 1'b0;
            2'b01:   g = (top2 == 2'b11);
            2'b10:   g = top2[1];
            default: g = 1'b1;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/wp_latch.sv
module wp_latch (
    input  logic clk,
    input  logic rst,
    input  logic txn_start,
    input  logic wp_pin,
    output logic wp_eff
);
    logic wp_q;

    always_ff @(posedge clk) begin
        if (rst)            wp_q <= 1'b0;
        else if (txn_start) wp_q <= wp_pin;
    end

    // a command in the start cycle already sees the fresh sample
    assign wp_eff = txn_start ? wp_pin : wp_q;

    AST_WP_HELD_MID_TXN: assert property (@(posedge clk) disable iff (rst)
        !txn_start |=> $stable(wp_q)); // R8

endmodule

// File: rtl/status_regs.sv
module status_regs
    import srwp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  cmd_e              kind,
    input  logic [STAT_W-1:0] data,
    input  logic              wp_eff,
    output stat_t             stat,
    output logic              upd
);
    stat_t d_in;
    logic  wr_allowed;

    always_comb begin
        d_in       = stat_t'(data);
        wr_allowed = stat.wel & (~stat.lock | wp_eff);
        upd        = cmd_valid && (kind == CMD_WSTAT) && wr_allowed;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
        end else if (cmd_valid) begin
            case (kind)
                CMD_WEN:  stat.wel <= 1'b1;
                CMD_WDIS: stat.wel <= 1'b0;
                CMD_WSTAT: begin
                    if (upd) begin
                        stat.lock     <= d_in.lock;
                        stat.spare_hi <= d_in.spare_hi;
                        stat.bp       <= d_in.bp;
                        stat.spare_lo <= d_in.spare_lo;
                    end
                end
                default: ;
            endcase
        end
    end

    AST_WEN_SETS_LATCH: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && kind == CMD_WEN) |=> stat.wel); // R2
    AST_WDIS_CLEARS_LATCH: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && kind == CMD_WDIS) |=> !stat.wel); // R2
    AST_UPD_KEEPS_LATCH: assert property (@(posedge clk) disable iff (rst)
        upd |=> $stable(stat.wel)); // R7
    AST_LOCKED_REFUSED: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && kind == CMD_WSTAT && stat.lock && !wp_eff) |=> $stable(stat)); // R5
    AST_NO_LATCH_NO_UPD: assert property (@(posedge clk) disable iff (rst)
        !stat.wel |-> !upd); // R3

endmodule

// File: rtl/range_guard.sv
module range_guard
    import srwp_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_D
) (
    input  logic [1:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              guarded
);
    localparam int TOP = ADDR_W - 1;

    logic [1:0] top2;

    generate
        if (ADDR_W >= 2) begin : g_wide
            assign top2 = addr[TOP -: 2];
        end else begin : g_narrow
            assign top2 = {addr[0], addr[0]};
        end
    endgenerate

    assign guarded = in_guarded(bp, top2);

endmodule

// File: rtl/status_guard.sv
module status_guard
    import srwp_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              txn_start,
    input  logic              wp_pin,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_kind,
    input  logic [STAT_W-1:0] cmd_data,
    input  logic [ADDR_W-1:0] mem_addr,
    output logic [STAT_W-1:0] status_out,
    output logic              mem_wr_ok,
    output logic              stat_upd
);
    cmd_e  kind;
    stat_t stat;
    logic  wp_eff;
    logic  guarded;

    assign kind = cmd_e'(cmd_kind);

    wp_latch u_wp (
        .clk       (clk),
        .rst       (rst),
        .txn_start (txn_start),
        .wp_pin    (wp_pin),
        .wp_eff    (wp_eff)
    );

    status_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .kind      (kind),
        .data      (cmd_data),
        .wp_eff    (wp_eff),
        .stat      (stat),
        .upd       (stat_upd)
    );

    range_guard #(.ADDR_W(ADDR_W)) u_range (
        .bp      (stat.bp),
        .addr    (mem_addr),
        .guarded (guarded)
    );

    assign status_out = stat;
    assign mem_wr_ok  = cmd_valid && (kind == CMD_MWR) && stat.wel && !guarded;

    AST_PERMIT_NEEDS_LATCH: assert property (@(posedge clk) disable iff (rst)
        mem_wr_ok |-> status_out[1]); // R3
    AST_FULL_GUARD: assert property (@(posedge clk) disable iff (rst)
        (status_out[3:2] == 2'b11) |-> !mem_wr_ok); // R6
    AST_MEM_WRITE_KEEPS_STATUS: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && kind == CMD_MWR) |=> $stable(status_out)); // R7
    AST_READ_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && kind == CMD_RSTAT) |=> $stable(status_out)); // R11

endmodule

// File: tb/status_guard_tb.sv
module status_guard_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        txn_start;
    logic        wp_pin;
    logic        cmd_valid;
    logic [2:0]  cmd_kind;
    logic [7:0]  cmd_data;
    logic [18:0] mem_addr;
    logic [7:0]  status_out;
    logic        mem_wr_ok;
    logic        stat_upd;

    int n_tests = 0;
    int n_fail  = 0;
    logic got_ok, got_upd;

    always #(CLK_PERIOD/2) clk = ~clk;

    status_guard u_dut (
        .clk(clk), .rst(rst), .txn_start(txn_start), .wp_pin(wp_pin),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_data(cmd_data),
        .mem_addr(mem_addr), .status_out(status_out), .mem_wr_ok(mem_wr_ok),
        .stat_upd(stat_upd)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // one command event; combinational outputs captured mid-cycle
    task automatic issue(input logic [2:0] k, input logic [7:0] d, input logic [18:0] a);
        cmd_valid = 1'b1; cmd_kind = k; cmd_data = d; mem_addr = a;
        #1;
        got_ok  = mem_wr_ok;
        got_upd = stat_upd;
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0; cmd_kind = 3'd0;
    endtask

    task automatic begin_txn(input logic wp);
        wp_pin = wp; txn_start = 1'b1;
        @(posedge clk); @(negedge clk);
        txn_start = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 status", status_out, 8'h00);
        chk("R1 permit", {7'd0, mem_wr_ok}, 8'h00);
        chk("R1 strobe", {7'd0, stat_upd}, 8'h00);
    endtask

    task automatic t_no_latch;
        begin_txn(1'b1);
        issue(3'd5, 8'h00, 19'h00000);
        chk("R3 mem permit", {7'd0, got_ok}, 8'h00);
        issue(3'd4, 8'h0C, 19'h0);
        chk("R3 strobe", {7'd0, got_upd}, 8'h00);
        chk("R3 status", status_out, 8'h00);
    endtask

    task automatic t_enable_and_bp;
        issue(3'd1, 8'h00, 19'h0);
        chk("R2 set", status_out, 8'h02);
        issue(3'd5, 8'h00, 19'h00000);
        chk("R6 bp00 permit", {7'd0, got_ok}, 8'h01);
        chk("R7 after mem write", status_out, 8'h02);
        issue(3'd4, 8'h7D, 19'h0);
        chk("R4 strobe", {7'd0, got_upd}, 8'h01);
        chk("R7 R4 status", status_out, 8'h7F);
        issue(3'd5, 8'h00, 19'h00000);
        chk("R6 bp11 addr0", {7'd0, got_ok}, 8'h00);
    endtask

    task automatic t_stream;
        logic [0:3] exp_q;
        issue(3'd4, 8'h04, 19'h0);
        chk("R4 bp01", status_out, 8'h06);
        exp_q = 4'b1100;
        for (int i = 0; i < 4; i++) begin
            issue(3'd5, 8'h00, 19'h5FFFE + 19'(i));
            chk("R9 R6 quarter stream", {7'd0, got_ok}, {7'd0, exp_q[i]});
        end
        issue(3'd4, 8'h08, 19'h0);
        chk("R4 bp10", status_out, 8'h0A);
        issue(3'd5, 8'h00, 19'h3FFFF);
        chk("R6 half below", {7'd0, got_ok}, 8'h01);
        issue(3'd5, 8'h00, 19'h40000);
        chk("R9 half above", {7'd0, got_ok}, 8'h00);
        issue(3'd4, 8'h71, 19'h0);
        chk("R10 free bits", status_out, 8'h73);
        issue(3'd5, 8'h00, 19'h7FFFF);
        chk("R10 top addr permit", {7'd0, got_ok}, 8'h01);
    endtask

    task automatic t_lock;
        issue(3'd4, 8'h80, 19'h0);
        chk("R4 set lock", status_out, 8'h82);
        begin_txn(1'b0);
        issue(3'd4, 8'h00, 19'h0);
        chk("R5 strobe", {7'd0, got_upd}, 8'h00);
        chk("R5 status", status_out, 8'h82);
        begin_txn(1'b0);
        wp_pin = 1'b1;
        issue(3'd4, 8'h00, 19'h0);
        chk("R8 late rise", status_out, 8'h82);
        begin_txn(1'b1);
        wp_pin = 1'b0;
        issue(3'd4, 8'h84, 19'h0);
        chk("R8 late fall strobe", {7'd0, got_upd}, 8'h01);
        chk("R8 late fall status", status_out, 8'h86);
    endtask

    task automatic t_misc;
        issue(3'd3, 8'hFF, 19'h0);
        chk("R11 read strobe", {7'd0, got_upd}, 8'h00);
        chk("R11 read status", status_out, 8'h86);
        issue(3'd7, 8'hFF, 19'h0);
        chk("R11 undefined", status_out, 8'h86);
        issue(3'd2, 8'h00, 19'h0);
        chk("R2 clear", status_out, 8'h84);
        issue(3'd5, 8'h00, 19'h00000);
        chk("R3 after clear", {7'd0, got_ok}, 8'h00);
    endtask

    initial begin
        rst = 1'b1; txn_start = 1'b0; wp_pin = 1'b0; cmd_valid = 1'b0;
        cmd_kind = 3'd0; cmd_data = 8'h00; mem_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_no_latch();
        t_enable_and_bp();
        t_stream();
        t_lock();
        t_misc();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule